// File: doc/BRIEF.md
# Folded Symmetric FIR Filter

This block is a nine-tap, eighth-order FIR filter with no feedback path and linear phase. Each output depends only on the newest sample and the eight samples before it. The coefficient set is mirror-symmetric, so h[k] equals h[8-k]. The two samples that share a coefficient are summed before the multiply. This leaves only five distinct products per output: four pre-added pairs and the unpaired centre tap.

Those five products are not computed in parallel. They are spread over `FOLD` consecutive clock cycles on a small bank of `ceil(5/FOLD)` multipliers. Fewer multipliers are needed, at the cost of latency and input rate.

A three-state controller runs each output:
- **IDLE**: waits for a sample.
- **MAC**: steps through the fold slots.
- **EMIT**: presents the rounded, saturated result for one cycle.

The transitions are:
- **accept**: IDLE to MAC, on `in_valid && in_ready`.
- **fold_done**: MAC to EMIT, after slot `FOLD-1`.
- **release**: EMIT to IDLE, unconditional.

Coefficients, data widths, output width, the rounding shift and the fold factor are all parameters. Resolution can be changed without touching the structure.

Top module: `fir_fold_sym`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. All nine history taps hold zero, so the first eight outputs see zero-padded history.
- R2: A sample is taken only on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 for the next `FOLD+1` cycles and returns to 1 in the cycle after the `out_valid` pulse.
- R3: `out_valid` is a single-cycle pulse. It is high in the cycle that begins `FOLD+1` edges after the accepting edge.
- R4: The exact sum is acc = sum over k=0..8 of h[k]*x[n-k], with h[k]=h[8-k]. Here x[n] is the sample just taken. Coefficient j (0..4) sits in bits [j*COEF_W +: COEF_W] of `COEFS` as a signed value, and h[8-j] = h[j].
- R5: The output is rounded half-up: floor((acc + 2^(SHIFT-1)) / 2^SHIFT). An exact half of an LSB therefore goes toward plus infinity, so +0.5 LSB gives 1 and -0.5 LSB gives 0.
- R6: A rounded value outside the signed `OUT_W` range is clamped to 2^(OUT_W-1)-1 or to -2^(OUT_W-1).
- R7: Samples offered while `in_ready` is 0 are ignored. They never enter the history and do not change later outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input sample is offered |
| in_data | input | DATA_W | Signed input sample |
| in_ready | output | 1 | The filter can take a sample this cycle |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | OUT_W | Signed filtered result, rounded and saturated |

## Verification
The bench drives impulses of +1 and -1 at the centre tap. These land exactly on half an LSB, so a design that rounds to nearest-away or truncates gives the wrong value at the centre position. Full-scale positive and negative steps push the gain of 1.5 past the output range; a design that wraps instead of clamping flips the sign there. The bench also keeps `in_valid` high with junk data throughout each busy window. A design that samples while busy shifts the history, and every later output then disagrees with the convolution model. The latency of each pulse is checked cycle by cycle, so an off-by-one in the fold counter shows up as a pulse in the wrong slot.

// File: rtl/fir_fold_pkg.sv
`timescale 1ns/1ps
package fir_fold_pkg;
    localparam int NUM_TAPS = 9;
    localparam int NUM_UNIQ = 5;
    localparam int CENTER   = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_EMIT = 2'd2
    } fir_state_t;
endpackage

// File: rtl/fir_tap_line.sv
`timescale 1ns/1ps
module fir_tap_line
    import fir_fold_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int PA_W   = DATA_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic signed [DATA_W-1:0]   din,
    output logic [NUM_UNIQ*PA_W-1:0]   pre_flat
);
    logic signed [DATA_W-1:0] taps [NUM_TAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TAPS; i++) taps[i] <= '0;
        end else if (shift_en) begin
            taps[0] <= din;
            for (int i = 1; i < NUM_TAPS; i++) taps[i] <= taps[i-1];
        end
    end

    // Mirrored pairs share a coefficient; the centre tap pairs with zero.
    for (genvar j = 0; j < NUM_UNIQ; j++) begin : g_pre
        if (j < CENTER) begin : g_pair
            assign pre_flat[j*PA_W +: PA_W] =
                PA_W'(taps[j]) + PA_W'(taps[NUM_TAPS-1-j]);
        end else begin : g_mid
            assign pre_flat[j*PA_W +: PA_W] = PA_W'(taps[j]);
        end
    end
endmodule

// File: rtl/fir_mac_lane.sv
`timescale 1ns/1ps
module fir_mac_lane
    import fir_fold_pkg::*;
#(
    parameter int LANE     = 0,
    parameter int NUM_MULT = 2,
    parameter int PA_W     = 13,
    parameter int COEF_W   = 12,
    parameter int CNT_W    = 2,
    parameter logic [NUM_UNIQ*COEF_W-1:0] COEFS = '0,
    localparam int PROD_W  = PA_W + COEF_W
) (
    input  logic [NUM_UNIQ*PA_W-1:0] pre_flat,
    input  logic [CNT_W-1:0]         slot,
    output logic signed [PROD_W-1:0] prod
);
    logic signed [PA_W-1:0]   op_a;
    logic signed [COEF_W-1:0] op_b;

    // Pick the pre-added sum and coefficient this lane owns in this slot.
    always_comb begin
        op_a = '0;
        op_b = '0;
        for (int j = 0; j < NUM_UNIQ; j++) begin
            if (int'(slot) * NUM_MULT + LANE == j) begin
                op_a = pre_flat[j*PA_W +: PA_W];
                op_b = COEFS[j*COEF_W +: COEF_W];
            end
        end
        prod = PROD_W'(op_a) * PROD_W'(op_b);
    end
endmodule

// File: rtl/fir_round_sat.sv
`timescale 1ns/1ps
module fir_round_sat #(
    parameter int ACC_W = 28,
    parameter int OUT_W = 12,
    parameter int SHIFT = 11
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] res
);
    localparam int EXT_W = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] MAXV =
        {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] MINV =
        {{(EXT_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] scaled;

    assign ext = EXT_W'(acc);

    if (SHIFT > 0) begin : g_round
        localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) <<< (SHIFT - 1);
        logic signed [EXT_W-1:0] biased;
        assign biased = ext + HALF;
        assign scaled = biased >>> SHIFT;
    end else begin : g_plain
        assign scaled = ext;
    end

    always_comb begin
        if (scaled > MAXV)      res = MAXV[OUT_W-1:0];
        else if (scaled < MINV) res = MINV[OUT_W-1:0];
        else                    res = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/fir_fold_sym.sv
`timescale 1ns/1ps
module fir_fold_sym
    import fir_fold_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int COEF_W = 12,
    parameter int OUT_W  = 12,
    parameter int SHIFT  = 11,
    parameter int FOLD   = 3,
    parameter logic [NUM_UNIQ*COEF_W-1:0] COEFS =
        {12'd1024, 12'd768, 12'd320, 12'd0, 12'hFC0}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     in_ready,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);
    localparam int PA_W     = DATA_W + 1;
    localparam int PROD_W   = PA_W + COEF_W;
    localparam int ACC_W    = PROD_W + $clog2(NUM_UNIQ);
    localparam int NUM_MULT = (NUM_UNIQ + FOLD - 1) / FOLD;
    localparam int CNT_W    = $clog2(FOLD + 1);

    fir_state_t state, nxt;
    logic [CNT_W-1:0]          slot;
    logic signed [ACC_W-1:0]   acc;
    logic signed [ACC_W-1:0]   lane_sum;
    logic [NUM_UNIQ*PA_W-1:0]  pre_flat;
    logic signed [PROD_W-1:0]  prods [NUM_MULT];
    logic                      accept;

    assign accept = in_valid && (state == ST_IDLE);

    fir_tap_line #(.DATA_W(DATA_W), .PA_W(PA_W)) i_taps (
        .clk(clk), .rst_n(rst_n), .shift_en(accept),
        .din(in_data), .pre_flat(pre_flat)
    );

    for (genvar m = 0; m < NUM_MULT; m++) begin : g_lane
        fir_mac_lane #(
            .LANE(m), .NUM_MULT(NUM_MULT), .PA_W(PA_W),
            .COEF_W(COEF_W), .CNT_W(CNT_W), .COEFS(COEFS)
        ) i_lane (
            .pre_flat(pre_flat), .slot(slot), .prod(prods[m])
        );
    end

    always_comb begin
        lane_sum = '0;
        for (int m = 0; m < NUM_MULT; m++) lane_sum = lane_sum + ACC_W'(prods[m]);
    end

    // State register, slot counter and accumulator.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slot  <= '0;
            acc   <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                slot <= '0;
                acc  <= '0;
            end else if (state == ST_MAC) begin
                slot <= slot + 1'b1;
                acc  <= acc + lane_sum;
            end
        end
    end

    // Transitions: accept, fold_done, release.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept) nxt = ST_MAC;
            ST_MAC:  if (slot == CNT_W'(FOLD - 1)) nxt = ST_EMIT;
            ST_EMIT: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_EMIT);
    end

    fir_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) i_rnd (
        .acc(acc), .res(out_data)
    );
endmodule

// File: rtl/fir_fold_checker.sv
`timescale 1ns/1ps
module fir_fold_checker #(
    parameter int FOLD = 3
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid
);
    int busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  busy_cnt <= 0;
        else if (in_valid && in_ready) busy_cnt <= 1;
        else if (out_valid)          busy_cnt <= 0;
        else if (busy_cnt != 0)      busy_cnt <= busy_cnt + 1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !out_valid));

    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_ready_after_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> in_ready);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (busy_cnt == FOLD + 1));

    assert_no_take_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != 0 && !out_valid) |-> !in_ready);
endmodule

bind fir_fold_sym fir_fold_checker #(.FOLD(FOLD)) i_fir_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_ready(in_ready), .out_valid(out_valid)
);

// File: tb/test_fir_fold_sym.sv
`timescale 1ns/1ps
module test_fir_fold_sym;
    localparam int DW = 12, CW = 12, OW = 12, SH = 11, FOLD = 3;
    localparam logic [5*CW-1:0] CF = {12'd1024, 12'd768, 12'd320, 12'd0, 12'hFC0};
    localparam longint H[9] = '{-64, 0, 320, 768, 1024, 768, 320, 0, -64};

    logic clk = 0, rst_n = 0, in_valid = 0;
    logic signed [DW-1:0] in_data = '0;
    logic in_ready, out_valid;
    logic signed [OW-1:0] out_data;

    int tests = 0, fails = 0;
    longint hist[9];

    always #4 clk = ~clk;

    fir_fold_sym #(.DATA_W(DW), .COEF_W(CW), .OUT_W(OW), .SHIFT(SH),
                   .FOLD(FOLD), .COEFS(CF)) i_fir_fold_sym (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data));

    function automatic longint model_push(input longint d);
        longint acc, r;
        for (int i = 8; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = d;
        acc = 0;
        for (int k = 0; k < 9; k++) acc += H[k] * hist[k];
        r = (acc + (64'sd1 <<< (SH-1))) >>> SH;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input longint got, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic send(input logic signed [DW-1:0] d, input bit noisy, input string tag);
        longint exp;
        bit tim_ok = 1, busy_ok = 1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_data = d;
        exp = model_push(longint'(d));
        for (int c = 1; c <= FOLD + 2; c++) begin
            @(negedge clk);
            if (c <= FOLD && (out_valid || in_ready)) busy_ok = 0;
            if (c == FOLD + 1) begin
                if (!out_valid || in_ready) tim_ok = 0;
                check(out_data == exp, tag, longint'(out_data), exp);
            end
            if (c == FOLD + 2 && (out_valid || !in_ready)) tim_ok = 0;
            if (noisy && c <= FOLD) begin
                in_valid = 1;
                in_data = DW'($urandom_range(0, 4095));
            end else begin
                in_valid = 0;
            end
        end
        check(tim_ok, "R3 pulse timing", tim_ok, 1);
        check(busy_ok, noisy ? "R7 busy while junk offered" : "R2 busy window",
              busy_ok, 1);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 9; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
        check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        // R1: first outputs on zero-padded history, impulse walks through taps
        send(12'sd16, 0, "R1 zero history");
        for (int i = 0; i < 8; i++) send(12'sd0, 0, "R4 impulse tail");
        // R5: half-LSB cases at the centre tap (+1 -> 1, -1 -> 0)
        send(12'sd1, 0, "R5 plus half");
        for (int i = 0; i < 4; i++) send(12'sd0, 0, "R5 plus half");
        for (int i = 0; i < 4; i++) send(12'sd0, 0, "R5 flush");
        send(-12'sd1, 0, "R5 minus half");
        for (int i = 0; i < 4; i++) send(12'sd0, 0, "R5 minus half");
        // R6: full-scale steps saturate
        for (int i = 0; i < 10; i++) send(12'sd2047, 0, "R6 positive clamp");
        for (int i = 0; i < 10; i++) send(-12'sd2048, 0, "R6 negative clamp");
        // R7: junk offered in busy windows must be ignored
        for (int i = 0; i < 20; i++) send(DW'($urandom_range(0, 4095)), 1, "R7 junk ignored");
        // R4: random convolution
        for (int i = 0; i < 60; i++) send(DW'($urandom_range(0, 4095)), 0, "R4 random");
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule